// File: doc/BRIEF.md
# Bitmap Display Driver Power-Up and Refresh Sequencer

This block sits on the host side of a serially loaded 16-row by 100-column bitmap display driver. A single start pulse sets off a complete bring-up. The block keeps the display turned off and pulses the driver's reset. It then shifts the whole bitmap out one row frame at a time over a chip-select, clock and data link. An optional contrast frame follows the rows. After a settling wait the block turns the display on and raises a done flag.

Pixel data is read from an external frame buffer through an address output and a data input. The buffer must return a row combinationally, in the same cycle that the address is presented. The contrast code and its enable are captured when the start pulse is taken. Every interval is a counter whose length the block derives from the system clock frequency, rounding up. A start pulse after the first completed bring-up refreshes the rows only. It does not reset the driver again, it does not wait again, and the display stays on throughout.

Top module: `lcd_host_seq`

## Requirements
- R1: Out of reset: display enable low, driver reset high (inactive), chip-select high (inactive), serial clock high, serial data low, done low.
- R2: The first start pulse drives the driver reset low for exactly RST_US*CLK_MHZ cycles (1300 us by default). The display enable stays low until bring-up completes.
- R3: Chip-select never goes low while the driver reset is low. Chip-select only falls while the serial clock is high.
- R4: Inside a frame, every low phase and every high phase of the serial clock lasts HALF_CYC = ceil(SCLK_HALF_NS*CLK_MHZ/1000) cycles. The first high phase is counted from the fall of chip-select. With the default 250 ns, the link runs at no more than 2 MHz.
- R5: Serial data changes only on a falling clock edge. It is stable while the clock is high and chip-select is low.
- R6: A row frame is exactly 105 bits, sampled on the rising clock edges. Bits 1 to 100 are row_data_i[0] through row_data_i[99], in that order. Bits 101 to 104 are the row number, MSB first. Bit 105 is 0.
- R7: Rows are sent in the order 0 to 15. row_addr_o carries the number of the row being loaded.
- R8: When contrast_en_i is high at start, a 17th frame follows the rows. It carries 100 zero bits, then the start-time contrast_i MSB first, then a 1. When contrast_en_i is low at start, no 17th frame is sent. Later changes to the contrast inputs have no effect on a run in progress.
- R9: Chip-select rises exactly HALF_CYC cycles after the last rising clock edge of a frame. It then stays high for at least HALF_CYC cycles before the next frame.
- R10: On the first bring-up, the display enable and done both rise exactly HALF_CYC + WAIT_US*CLK_MHZ cycles after the final chip-select rise.
- R11: A start pulse after done has been set does the following: no driver reset pulse, the display enable stays high, done drops, and done rises again exactly HALF_CYC cycles after the final chip-select rise.
- R12: A start pulse while a run is in progress is ignored. No extra frames are sent, and the bus stays idle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse |
| contrast_en_i | input | 1 | Send contrast frame in this run |
| contrast_i | input | 4 | Contrast code |
| row_addr_o | output | 4 | Frame buffer row address |
| row_data_i | input | 100 | Frame buffer row, column 0 in bit 0 |
| disp_en_o | output | 1 | Display enable to driver, high = on |
| drv_rst_no | output | 1 | Driver reset, active low |
| cs_no | output | 1 | Serial chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| done_o | output | 1 | Display enabled and all frames written |

## Verification
The bench decodes every frame at the driver pins and compares it with a frame built from the buffer contents. Its row patterns include all-zero, all-one and asymmetric rows, and its contrast codes are asymmetric. A reversed bit order, a row tag sent LSB first, or a wrong trailing bit would each show up as a frame mismatch.

Phase lengths, the chip-select hold and gap, and the reset and settling intervals are each measured to the exact cycle. An off-by-one in any counter, or a settling wait that is skipped, would be caught.

A refresh run is checked for a second reset pulse or a display dropout. The bench also issues a start pulse mid-run and changes the contrast code mid-run. A design that re-arms on either would send extra frames or the wrong contrast value.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_LOAD, ST_CSSU, ST_LO, ST_HI, ST_GAP, ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/lcd_seq_tmr.sv
module lcd_seq_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_seq_framer.sv
module lcd_seq_framer #(
  parameter int NUM_SEG = 100,
  parameter int NUM_ROW = 16,
  parameter int ROW_W   = 4,
  parameter int FIDX_W  = 5,
  parameter int FRAME_W = 105
) (
  input  logic [NUM_SEG-1:0] row_data_i,
  input  logic [FIDX_W-1:0]  fidx_i,
  input  logic [ROW_W-1:0]   ctr_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic             is_ctr;
  logic [ROW_W-1:0] tag;

  assign is_ctr = (fidx_i == FIDX_W'(NUM_ROW));
  assign tag    = is_ctr ? ctr_i : fidx_i[ROW_W-1:0];

  assign frame_o[NUM_SEG-1:0] = is_ctr ? '0 : row_data_i;
  assign frame_o[FRAME_W-1]   = is_ctr;

  // tag goes out MSB first, right after the pixel bits
  for (genvar i = 0; i < ROW_W; i++) begin : g_tag
    assign frame_o[FRAME_W-2-i] = tag[i];
  end
endmodule

// File: rtl/lcd_seq_shift.sv
module lcd_seq_shift #(
  parameter int W = 105
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] d_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= d_i;
    else if (shift_i) q <= q >> 1;
  end

  assign bit_o = q[0];
endmodule

// File: rtl/lcd_host_seq.sv
module lcd_host_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int RST_US       = 1300,
  parameter int WAIT_US      = 100000,
  parameter int SCLK_HALF_NS = 250,
  parameter int NUM_SEG      = 100,
  parameter int NUM_ROW      = 16,
  parameter int CTR_W        = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       contrast_en_i,
  input  logic [CTR_W-1:0]           contrast_i,
  output logic [$clog2(NUM_ROW)-1:0] row_addr_o,
  input  logic [NUM_SEG-1:0]         row_data_i,
  output logic                       disp_en_o,
  output logic                       drv_rst_no,
  output logic                       cs_no,
  output logic                       sclk_o,
  output logic                       sdata_o,
  output logic                       done_o
);
  localparam int ROW_W    = $clog2(NUM_ROW);
  localparam int FIDX_W   = ROW_W + 1;
  localparam int FRAME_W  = NUM_SEG + ROW_W + 1;
  localparam int BIT_W    = $clog2(FRAME_W);
  localparam int HALF_CYC = (SCLK_HALF_NS * CLK_MHZ + 999) / 1000;
  localparam int RST_CYC  = RST_US * CLK_MHZ;
  localparam int WAIT_CYC = WAIT_US * CLK_MHZ;
  localparam int TMR_MAX  = (WAIT_CYC > RST_CYC) ?
                            ((WAIT_CYC > HALF_CYC) ? WAIT_CYC : HALF_CYC) :
                            ((RST_CYC > HALF_CYC) ? RST_CYC : HALF_CYC);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  seq_state_e         st_q, st_d;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_zero, tmr_ld;
  logic [BIT_W-1:0]   bit_q;
  logic [FIDX_W-1:0]  fidx_q;
  logic               cen_q, up_q;
  logic [CTR_W-1:0]   cval_q;
  logic [FRAME_W-1:0] frame;
  logic               sh_bit, last_bit, last_frm;

  assign last_bit   = (bit_q == BIT_W'(FRAME_W - 1));
  assign last_frm   = cen_q ? (fidx_q == FIDX_W'(NUM_ROW)) : (fidx_q == FIDX_W'(NUM_ROW - 1));
  assign row_addr_o = fidx_q[ROW_W-1:0];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)  st_d = up_q ? ST_LOAD : ST_RST;
      ST_RST:  if (tmr_zero) st_d = ST_LOAD;
      ST_LOAD:               st_d = ST_CSSU;
      ST_CSSU: if (tmr_zero) st_d = ST_LO;
      ST_LO:   if (tmr_zero) st_d = ST_HI;
      ST_HI:   if (tmr_zero) st_d = last_bit ? ST_GAP : ST_LO;
      ST_GAP:  if (tmr_zero) st_d = !last_frm ? ST_LOAD : (up_q ? ST_IDLE : ST_WAIT);
      ST_WAIT: if (tmr_zero) st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  // every state change reloads the interval of the state being entered
  assign tmr_ld  = (st_d != st_q);
  assign tmr_val = (st_d == ST_RST)  ? TMR_W'(RST_CYC - 1)  :
                   (st_d == ST_WAIT) ? TMR_W'(WAIT_CYC - 1) : TMR_W'(HALF_CYC - 1);

  lcd_seq_tmr #(.W(TMR_W)) i_tmr (
    .clk_i, .rst_ni, .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  lcd_seq_framer #(
    .NUM_SEG(NUM_SEG), .NUM_ROW(NUM_ROW), .ROW_W(ROW_W),
    .FIDX_W(FIDX_W), .FRAME_W(FRAME_W)
  ) i_framer (
    .row_data_i, .fidx_i(fidx_q), .ctr_i(ROW_W'(cval_q)), .frame_o(frame)
  );

  lcd_seq_shift #(.W(FRAME_W)) i_shift (
    .clk_i, .rst_ni,
    .load_i (st_q == ST_LOAD),
    .shift_i(st_q != ST_LO && st_d == ST_LO),
    .d_i    (frame),
    .bit_o  (sh_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_q      <= '0;
      fidx_q     <= '0;
      cen_q      <= 1'b0;
      cval_q     <= '0;
      up_q       <= 1'b0;
      disp_en_o  <= 1'b0;
      drv_rst_no <= 1'b1;
      cs_no      <= 1'b1;
      sclk_o     <= 1'b1;
      sdata_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        done_o <= 1'b0;
        cen_q  <= contrast_en_i;
        cval_q <= contrast_i;
        fidx_q <= '0;
        if (!up_q) drv_rst_no <= 1'b0;
      end
      if (st_q == ST_RST && st_d == ST_LOAD) drv_rst_no <= 1'b1;
      if (st_q == ST_LOAD) bit_q <= '0;
      if (st_d == ST_CSSU) cs_no <= 1'b0;
      if (st_q != ST_LO && st_d == ST_LO) begin
        sclk_o  <= 1'b0;
        sdata_o <= sh_bit;
      end
      if (st_q == ST_HI && st_d == ST_LO) bit_q <= bit_q + 1'b1;
      if (st_q == ST_LO && st_d == ST_HI) sclk_o <= 1'b1;
      if (st_q == ST_HI && st_d == ST_GAP) cs_no <= 1'b1;
      if (st_q == ST_GAP && st_d == ST_LOAD) fidx_q <= fidx_q + 1'b1;
      if (st_q != ST_IDLE && st_d == ST_IDLE) begin
        done_o <= 1'b1;
        if (st_q == ST_WAIT) begin
          disp_en_o <= 1'b1;
          up_q      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_host_seq_chk.sv
module lcd_host_seq_chk #(
  parameter int HALF_CYC = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic disp_en_o,
  input logic drv_rst_no,
  input logic cs_no,
  input logic sclk_o,
  input logic sdata_o,
  input logic done_o
);
  int lo_cnt, gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= 0;
      gap_cnt <= HALF_CYC;
    end else begin
      lo_cnt  <= sclk_o ? 0 : lo_cnt + 1;
      gap_cnt <= !cs_no ? 0 : ((gap_cnt < HALF_CYC) ? gap_cnt + 1 : gap_cnt);
    end
  end

  assert_rst_keeps_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_rst_no |-> !disp_en_o);

  assert_cs_after_rst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> drv_rst_no);

  assert_cs_fall_clk_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sclk_o);

  assert_low_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && !cs_no) |-> (lo_cnt == HALF_CYC));

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_cs_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (gap_cnt >= HALF_CYC));

  assert_done_display_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> disp_en_o);

  assert_display_stays_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_o |=> disp_en_o);
endmodule

bind lcd_host_seq lcd_host_seq_chk #(.HALF_CYC(HALF_CYC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_en_o(disp_en_o), .drv_rst_no(drv_rst_no),
  .cs_no(cs_no), .sclk_o(sclk_o), .sdata_o(sdata_o), .done_o(done_o)
);

// File: tb/test_lcd_host_seq.sv
module test_lcd_host_seq;
  localparam int MHZ  = 20;
  localparam int RUS  = 13;
  localparam int WUS  = 100;
  localparam int FW   = 105;
  localparam int HALF = (250 * MHZ + 999) / 1000;
  localparam int RCYC = RUS * MHZ;
  localparam int WCYC = WUS * MHZ;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cen = 1'b0;
  logic [3:0]  cval = '0;
  logic [3:0]  raddr;
  logic [99:0] rdata;
  logic en, drst_n, cs_n, sclk, sd, done;
  logic [99:0] mem [16];

  int checks = 0, errors = 0;
  logic       exp_cen = 1'b0;
  logic [3:0] exp_cv = '0;

  always #5 clk = ~clk;
  assign rdata = mem[raddr];

  lcd_host_seq #(.CLK_MHZ(MHZ), .RST_US(RUS), .WAIT_US(WUS)) i_lcd_host_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .contrast_en_i(cen),
    .contrast_i(cval), .row_addr_o(raddr), .row_data_i(rdata), .disp_en_o(en),
    .drv_rst_no(drst_n), .cs_no(cs_n), .sclk_o(sclk), .sdata_o(sd), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [FW-1:0] exp_frame(input int idx);
    logic [FW-1:0] f;
    logic [3:0] tag;
    f   = '0;
    tag = (idx < 16) ? 4'(idx) : exp_cv;
    if (idx < 16) f[99:0] = mem[idx];
    for (int i = 0; i < 4; i++) f[100+i] = tag[3-i];
    f[104] = (idx >= 16);
    return f;
  endfunction

  // pin-level monitor
  logic p_cs = 1'b1, p_sclk = 1'b1, p_sd = 1'b0, p_en = 1'b0, p_done = 1'b0;
  logic [FW-1:0] cap = '0;
  int cyc = 0, nbits = 0, fcnt = 0, t_rise = 0, t_fall = 0, t_hi = 0, t_csr = 0;
  int t_en = 0, t_done = 0, drst_low = 0, en_bad = 0, en_fall = 0, sd_bad = 0;
  int run_fbase = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!drst_n) drst_low++;
    if (en && !done && fcnt < 17) en_bad++;
    if (!en && p_en) en_fall++;
    if (!cs_n && p_cs) begin
      chk(sclk == 1'b1, "R3 cs fall with sclk high", sclk, 1);
      chk(drst_n == 1'b1, "R3 cs low only after reset", drst_n, 1);
      if (fcnt > run_fbase) chk(cyc - t_csr >= HALF, "R9 cs gap", cyc - t_csr, HALF);
      nbits = 0;
      t_hi  = cyc;
    end
    if (!cs_n && !p_cs && sclk && !p_sclk) begin
      chk(cyc - t_fall == HALF, "R4 low phase", cyc - t_fall, HALF);
      if (nbits < FW) cap[nbits] = sd;
      nbits++;
      t_rise = cyc;
      t_hi   = cyc;
    end
    if (!cs_n && !p_cs && !sclk && p_sclk) begin
      chk(cyc - t_hi == HALF, "R4 high phase", cyc - t_hi, HALF);
      t_fall = cyc;
    end
    if (!cs_n && !p_cs && sclk && p_sclk && sd != p_sd) sd_bad++;
    if (cs_n && !p_cs) begin
      chk(cyc - t_rise == HALF, "R9 cs hold", cyc - t_rise, HALF);
      chk(nbits == FW, "R6 frame length", nbits, FW);
      chk(cap == exp_frame(fcnt - run_fbase), "R6/R7/R8 frame content R6 R7 R8",
          fcnt - run_fbase, fcnt - run_fbase);
      if (cap != exp_frame(fcnt - run_fbase))
        $display("  frame %0d got %h want %h", fcnt - run_fbase, cap, exp_frame(fcnt - run_fbase));
      fcnt++;
      t_csr = cyc;
    end
    if (en && !p_en) t_en = cyc;
    if (done && !p_done) t_done = cyc;
    p_cs = cs_n; p_sclk = sclk; p_sd = sd; p_en = en; p_done = done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic fill(input int mode);
    for (int r = 0; r < 16; r++)
      mem[r] = {$urandom, $urandom, $urandom, $urandom};
    if (mode == 0) begin
      mem[0]  = '0;
      mem[15] = '1;
    end else if (mode == 2) begin
      mem[3] = {50{2'b01}};
      mem[9] = 100'h1;
    end
  endtask

  initial begin
    int b_drst, b_enf;
    void'($urandom(32'd4242));
    fill(0);
    repeat (3) @(negedge clk);
    chk(en == 0 && drst_n == 1 && cs_n == 1 && sclk == 1 && sd == 0 && done == 0,
        "R1 reset state", {en, drst_n, cs_n, sclk, sd, done}, 6'b011100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(en == 0 && drst_n == 1 && cs_n == 1 && done == 0, "R1 idle before start",
        {en, drst_n, cs_n, done}, 4'b0110);

    // run 1: bring-up with contrast 1010
    @(posedge clk);
    run_fbase = fcnt; exp_cen = 1'b1; exp_cv = 4'hA;
    cen = 1'b1; cval = 4'hA;
    pulse_start();
    wait (done == 1'b1);
    @(posedge clk);
    @(posedge clk);
    chk(drst_low == RCYC, "R2 reset low length", drst_low, RCYC);
    chk(en_bad == 0, "R2 display off until done", en_bad, 0);
    chk(fcnt - run_fbase == 17, "R8 frame count with contrast", fcnt - run_fbase, 17);
    chk(t_en - t_csr == HALF + WCYC, "R10 settle wait", t_en - t_csr, HALF + WCYC);
    chk(t_done == t_en, "R10 done with enable", t_done, t_en);
    chk(sd_bad == 0, "R5 data stable while clock high", sd_bad, 0);

    // run 2: refresh without contrast, stray start mid-run
    fill(1);
    @(posedge clk);
    run_fbase = fcnt; exp_cen = 1'b0; b_drst = drst_low; b_enf = en_fall;
    cen = 1'b0;
    pulse_start();
    wait (done == 1'b0);
    wait (fcnt == run_fbase + 3);
    pulse_start();
    wait (done == 1'b1);
    @(posedge clk);
    @(posedge clk);
    chk(drst_low == b_drst, "R11 no reset on refresh", drst_low - b_drst, 0);
    chk(en_fall == b_enf && en == 1, "R11 display stays on", en_fall - b_enf, 0);
    chk(t_done - t_csr == HALF, "R11 done after last frame", t_done - t_csr, HALF);
    chk(fcnt - run_fbase == 16, "R8 R12 frame count without contrast", fcnt - run_fbase, 16);
    repeat (300) @(negedge clk);
    chk(cs_n == 1 && fcnt - run_fbase == 16, "R12 bus idle after stray start",
        fcnt - run_fbase, 16);

    // run 3: refresh with contrast 0011, inputs change mid-run
    fill(2);
    @(posedge clk);
    run_fbase = fcnt; exp_cen = 1'b1; exp_cv = 4'h3;
    cen = 1'b1; cval = 4'h3;
    pulse_start();
    @(negedge clk) begin cval = 4'hC; cen = 1'b0; end
    wait (done == 1'b0);
    wait (done == 1'b1);
    @(posedge clk);
    @(posedge clk);
    chk(fcnt - run_fbase == 17, "R8 contrast latched at start", fcnt - run_fbase, 17);
    chk(sd_bad == 0, "R5 data stable overall", sd_bad, 0);
    chk(en == 1, "R11 display on after refresh", en, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule